// File: doc/BRIEF.md
# I2C Slave Byte Buffer Controller

This block manages the byte buffers and status flags that sit between a processor-facing register port and the serial shift path of an I2C slave. It keeps one transmit byte that the processor writes and one receive byte that the processor reads. It decides when the transmit byte moves into the output shift path, and it keeps the transmit-empty, receive-full and overrun flags up to date.

The protocol engine sends it single-cycle indications: an address match together with the direction bit, the end of an outgoing byte together with the acknowledge bit the master returned, and the end of an incoming byte together with its value. In return the block drives a one-cycle load strobe with the byte for the shifter, and a request to release SDA after the master has declined a byte. The block does nothing while its enable input is low.

Top module: `sbuf_ctrl`

## Requirements
- R1: After reset the transmit register reads all ones (0xFF), `txbe` is 1, and `rxbf`, `rx_ovr`, `sda_release` and `shift_load` are 0.
- R2: A rising `addr_match` with `rw_read`=1 (read request) makes `shift_load` high in the next cycle, with `shift_data` equal to the transmit register value at that edge.
- R3: A `tx_done` pulse with `ack_bit`=0 (master acknowledge) causes the same load in the next cycle, unless a declined byte is still held back (R5).
- R4: The load strobe lasts exactly one cycle, and one qualifying event gives exactly one strobe, however long that event is held.
- R5: A `tx_done` with `ack_bit`=1 (master no-acknowledge) raises `sda_release` in the next cycle and causes no load. The transmit byte and `txbe`=0 are kept, and acknowledge events are ignored until the next address match. That address match clears `sda_release`, and if it is a read, it loads the held byte.
- R6: `txbe` is set in the same cycle the load strobe appears. A processor write stores the byte and clears `txbe`. When a write and a load happen on the same edge, the load takes the old byte and `txbe` ends at 0.
- R7: A completed incoming byte (`rx_done`) arriving while `rxbf`=0 is stored in the receive register, and `rxbf` reads 1 in the next cycle.
- R8: A processor read (`cpu_rx_re`) clears `rxbf` and `rx_ovr`.
- R9: A completed incoming byte arriving while `rxbf`=1, with no read on the same edge, leaves the receive register unchanged and sets `rx_ovr`.
- R10: If a read and a completed byte happen on the same edge, the new byte is stored, `rxbf` stays 1 and `rx_ovr` stays 0.
- R11: While `enable`=0, no register, flag or strobe changes, whatever arrives on the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| cpu_tx_we | input | 1 | Processor write strobe for the transmit register |
| cpu_tx_wdata | input | W | Byte written to the transmit register |
| cpu_tx_rdata | output | W | Current transmit register contents |
| cpu_rx_re | input | 1 | Processor read strobe for the receive register |
| cpu_rx_rdata | output | W | Current receive register contents |
| addr_match | input | 1 | Protocol engine: own address recognised |
| rw_read | input | 1 | Protocol engine: direction bit, 1 = master reads |
| tx_done | input | 1 | Protocol engine: outgoing byte finished, acknowledge sampled |
| ack_bit | input | 1 | Acknowledge bit from the master, 0 = acknowledge |
| rx_done | input | 1 | Protocol engine: incoming byte complete |
| rx_byte | input | W | Incoming byte value |
| shift_load | output | 1 | One-cycle load strobe to the output shifter |
| shift_data | output | W | Byte handed to the shifter |
| txbe | output | 1 | Transmit register empty |
| rxbf | output | 1 | Receive register full |
| rx_ovr | output | 1 | Receive overrun |
| sda_release | output | 1 | Request to release SDA after a no-acknowledge |

## Verification
The assertions assume that the protocol engine never signals `tx_done` and `addr_match` in the same cycle. They also assume that all inputs are defined from the first clock edge after reset. The bench drives every input to a known value from time zero. It changes inputs only one time unit after a rising edge, and it raises each protocol indication for a single cycle, except in the hold test, which deliberately keeps a read request high for three cycles.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        LOAD_NONE = 2'd0,
        LOAD_ADDR = 2'd1,
        LOAD_ACK  = 2'd2
    } load_cause_e;

    function automatic load_cause_e pick_cause(input logic addr_rd, input logic ack_ok);
        if (addr_rd)     return LOAD_ADDR;
        else if (ack_ok) return LOAD_ACK;
        else             return LOAD_NONE;
    endfunction

endpackage

// File: rtl/sbuf_tx_path.sv
module sbuf_tx_path
    import sbuf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         cpu_tx_we,
    input  logic [W-1:0] cpu_tx_wdata,
    input  logic         addr_match,
    input  logic         rw_read,
    input  logic         tx_done,
    input  logic         ack_bit,
    output logic [W-1:0] tx_reg,
    output logic         shift_load,
    output logic [W-1:0] shift_data,
    output logic         txbe,
    output logic         sda_release
);

    localparam logic [W-1:0] TX_RST = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] sdata;
        logic         load;
        logic         empty;
        logic         release_sda;
        logic         hold;
        logic         prev;
    } tx_state_t;

    tx_state_t st_q, st_d;
    load_cause_e cause;

    always_comb begin
        logic addr_rd;
        logic ack_ok;
        logic cond;
        st_d      = st_q;
        st_d.load = 1'b0;
        addr_rd   = addr_match & rw_read;
        ack_ok    = tx_done & ~ack_bit & ~st_q.hold;
        cause     = pick_cause(addr_rd, ack_ok);
        cond      = (cause != LOAD_NONE);
        if (enable) begin
            st_d.prev = cond;
            if (cond && !st_q.prev) begin
                st_d.load  = 1'b1;
                st_d.sdata = st_q.data;
                st_d.empty = 1'b1;
            end
            if (addr_match) begin
                st_d.release_sda = 1'b0;
                st_d.hold        = 1'b0;
            end else if (tx_done && ack_bit) begin
                st_d.release_sda = 1'b1;
                st_d.hold        = 1'b1;
            end
            if (cpu_tx_we) begin
                st_d.data  = cpu_tx_wdata;
                st_d.empty = 1'b0;
            end
        end else begin
            st_d.prev = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data        <= TX_RST;
            st_q.sdata       <= '0;
            st_q.load        <= 1'b0;
            st_q.empty       <= 1'b1;
            st_q.release_sda <= 1'b0;
            st_q.hold        <= 1'b0;
            st_q.prev        <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_reg      = st_q.data;
    assign shift_load  = st_q.load;
    assign shift_data  = st_q.sdata;
    assign txbe        = st_q.empty;
    assign sda_release = st_q.release_sda;

endmodule

// File: rtl/sbuf_rx_path.sv
module sbuf_rx_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         cpu_rx_re,
    input  logic         rx_done,
    input  logic [W-1:0] rx_byte,
    output logic [W-1:0] rx_reg,
    output logic         rxbf,
    output logic         rx_ovr
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         full;
        logic         ovr;
    } rx_state_t;

    rx_state_t st_q, st_d;

    always_comb begin
        logic room;
        st_d = st_q;
        room = ~st_q.full | cpu_rx_re;
        if (enable) begin
            if (cpu_rx_re) begin
                st_d.full = 1'b0;
                st_d.ovr  = 1'b0;
            end
            if (rx_done) begin
                if (room) begin
                    st_d.data = rx_byte;
                    st_d.full = 1'b1;
                end else begin
                    st_d.ovr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data <= '0;
            st_q.full <= 1'b0;
            st_q.ovr  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_reg = st_q.data;
    assign rxbf   = st_q.full;
    assign rx_ovr = st_q.ovr;

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         cpu_tx_we,
    input  logic [W-1:0] cpu_tx_wdata,
    output logic [W-1:0] cpu_tx_rdata,
    input  logic         cpu_rx_re,
    output logic [W-1:0] cpu_rx_rdata,
    input  logic         addr_match,
    input  logic         rw_read,
    input  logic         tx_done,
    input  logic         ack_bit,
    input  logic         rx_done,
    input  logic [W-1:0] rx_byte,
    output logic         shift_load,
    output logic [W-1:0] shift_data,
    output logic         txbe,
    output logic         rxbf,
    output logic         rx_ovr,
    output logic         sda_release
);

    sbuf_tx_path #(.W(W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .cpu_tx_we    (cpu_tx_we),
        .cpu_tx_wdata (cpu_tx_wdata),
        .addr_match   (addr_match),
        .rw_read      (rw_read),
        .tx_done      (tx_done),
        .ack_bit      (ack_bit),
        .tx_reg       (cpu_tx_rdata),
        .shift_load   (shift_load),
        .shift_data   (shift_data),
        .txbe         (txbe),
        .sda_release  (sda_release)
    );

    sbuf_rx_path #(.W(W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cpu_rx_re (cpu_rx_re),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .rx_reg    (cpu_rx_rdata),
        .rxbf      (rxbf),
        .rx_ovr    (rx_ovr)
    );

endmodule

// File: rtl/sbuf_ctrl_chk.sv
module sbuf_ctrl_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         cpu_tx_we,
    input logic [W-1:0] cpu_tx_wdata,
    input logic [W-1:0] cpu_tx_rdata,
    input logic         cpu_rx_re,
    input logic [W-1:0] cpu_rx_rdata,
    input logic         addr_match,
    input logic         rw_read,
    input logic         tx_done,
    input logic         ack_bit,
    input logic         rx_done,
    input logic [W-1:0] rx_byte,
    input logic         shift_load,
    input logic [W-1:0] shift_data,
    input logic         txbe,
    input logic         rxbf,
    input logic         rx_ovr,
    input logic         sda_release
);

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |=> !shift_load);

    p_addr_read_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable && addr_match && rw_read && !shift_load && $past(!(addr_match && rw_read))
        |=> shift_load);

    p_empty_with_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enable && cpu_tx_we |=> !txbe && cpu_tx_rdata == $past(cpu_tx_wdata));

    p_nack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enable && tx_done && ack_bit && !addr_match |=> sda_release && !shift_load);

    p_nack_keeps_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enable && tx_done && ack_bit && !addr_match && !cpu_tx_we |=> $stable(cpu_tx_rdata));

    p_rx_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enable && rx_done && !rxbf |=> rxbf && cpu_rx_rdata == $past(rx_byte));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enable && cpu_rx_re && !rx_done |=> !rxbf && !rx_ovr);

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enable && rx_done && rxbf && !cpu_rx_re |=> rx_ovr && $stable(cpu_rx_rdata));

    p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !shift_load && $stable(txbe) && $stable(rxbf) && $stable(rx_ovr)
                    && $stable(cpu_tx_rdata) && $stable(cpu_rx_rdata) && $stable(sda_release));

endmodule

bind sbuf_ctrl sbuf_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/sbuf_ctrl_bench.sv
module sbuf_ctrl_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         cpu_tx_we = 1'b0;
    logic [W-1:0] cpu_tx_wdata = '0;
    logic [W-1:0] cpu_tx_rdata;
    logic         cpu_rx_re = 1'b0;
    logic [W-1:0] cpu_rx_rdata;
    logic         addr_match = 1'b0;
    logic         rw_read = 1'b0;
    logic         tx_done = 1'b0;
    logic         ack_bit = 1'b0;
    logic         rx_done = 1'b0;
    logic [W-1:0] rx_byte = '0;
    logic         shift_load;
    logic [W-1:0] shift_data;
    logic         txbe;
    logic         rxbf;
    logic         rx_ovr;
    logic         sda_release;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sbuf_ctrl #(.W(W)) u_sbuf_ctrl (.*);

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_pulses();
        cpu_tx_we  = 1'b0;
        cpu_rx_re  = 1'b0;
        addr_match = 1'b0;
        rw_read    = 1'b0;
        tx_done    = 1'b0;
        ack_bit    = 1'b0;
        rx_done    = 1'b0;
    endtask

    task automatic cpu_write(input logic [W-1:0] v);
        cpu_tx_we = 1'b1; cpu_tx_wdata = v;
        tick(); clear_pulses();
    endtask

    task automatic test_reset();
        check("R1", "tx reg", cpu_tx_rdata, 8'hFF);
        check("R1", "txbe", txbe, 1);
        check("R1", "rxbf", rxbf, 0);
        check("R1", "rx_ovr", rx_ovr, 0);
        check("R1", "sda_release", sda_release, 0);
        check("R1", "shift_load", shift_load, 0);
    endtask

    task automatic test_addr_read();
        cpu_write(8'hA5);
        check("R6", "txbe after write", txbe, 0);
        addr_match = 1'b1; rw_read = 1'b1;
        tick(); clear_pulses();
        check("R2", "load strobe", shift_load, 1);
        check("R2", "shift data", shift_data, 8'hA5);
        check("R6", "txbe with strobe", txbe, 1);
        tick();
        check("R4", "strobe one cycle", shift_load, 0);
    endtask

    task automatic test_ack_load();
        cpu_write(8'h3C);
        tx_done = 1'b1; ack_bit = 1'b0;
        tick(); clear_pulses();
        check("R3", "ack load strobe", shift_load, 1);
        check("R3", "ack shift data", shift_data, 8'h3C);
        tick();
    endtask

    task automatic test_held_event();
        int strobes = 0;
        cpu_write(8'h5E);
        addr_match = 1'b1; rw_read = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (shift_load) strobes++;
        end
        clear_pulses();
        for (int i = 0; i < 2; i++) begin
            tick();
            if (shift_load) strobes++;
        end
        check("R4", "strobes for held event", strobes, 1);
    endtask

    task automatic test_nack();
        cpu_write(8'h77);
        tx_done = 1'b1; ack_bit = 1'b1;
        tick(); clear_pulses();
        check("R5", "release after nack", sda_release, 1);
        check("R5", "no load on nack", shift_load, 0);
        check("R5", "txbe stays 0", txbe, 0);
        check("R5", "byte kept", cpu_tx_rdata, 8'h77);
        tick();
        tx_done = 1'b1; ack_bit = 1'b0;
        tick(); clear_pulses();
        check("R5", "ack ignored while held", shift_load, 0);
        addr_match = 1'b1; rw_read = 1'b1;
        tick(); clear_pulses();
        check("R5", "held byte loaded", shift_load, 1);
        check("R5", "held byte value", shift_data, 8'h77);
        check("R5", "release cleared", sda_release, 0);
        tick();
    endtask

    task automatic test_write_collide();
        cpu_tx_we = 1'b1; cpu_tx_wdata = 8'h11;
        addr_match = 1'b1; rw_read = 1'b1;
        tick(); clear_pulses();
        check("R6", "collide load", shift_load, 1);
        check("R6", "collide old byte", shift_data, 8'h77);
        check("R6", "collide txbe", txbe, 0);
        check("R6", "collide new reg", cpu_tx_rdata, 8'h11);
        tick();
    endtask

    task automatic test_rx();
        rx_done = 1'b1; rx_byte = 8'h5A;
        tick(); clear_pulses();
        check("R7", "rxbf set", rxbf, 1);
        check("R7", "rx data", cpu_rx_rdata, 8'h5A);
        rx_done = 1'b1; rx_byte = 8'h66;
        tick(); clear_pulses();
        check("R9", "overrun flag", rx_ovr, 1);
        check("R9", "rx data kept", cpu_rx_rdata, 8'h5A);
        cpu_rx_re = 1'b1;
        tick(); clear_pulses();
        check("R8", "rxbf cleared", rxbf, 0);
        check("R8", "ovr cleared", rx_ovr, 0);
    endtask

    task automatic test_rx_same_edge();
        rx_done = 1'b1; rx_byte = 8'h21;
        tick(); clear_pulses();
        cpu_rx_re = 1'b1; rx_done = 1'b1; rx_byte = 8'h43;
        tick(); clear_pulses();
        check("R10", "rxbf stays", rxbf, 1);
        check("R10", "new byte stored", cpu_rx_rdata, 8'h43);
        check("R10", "no overrun", rx_ovr, 0);
    endtask

    task automatic test_disabled();
        enable = 1'b0;
        tick();
        cpu_tx_we = 1'b1; cpu_tx_wdata = 8'h99;
        addr_match = 1'b1; rw_read = 1'b1;
        rx_done = 1'b1; rx_byte = 8'hEE; cpu_rx_re = 1'b1;
        tick(); clear_pulses();
        check("R11", "no load", shift_load, 0);
        check("R11", "tx reg kept", cpu_tx_rdata, 8'h11);
        check("R11", "rx reg kept", cpu_rx_rdata, 8'h43);
        check("R11", "rxbf kept", rxbf, 1);
        check("R11", "txbe kept", txbe, 0);
        tx_done = 1'b1; ack_bit = 1'b1;
        tick(); clear_pulses();
        check("R11", "no release", sda_release, 0);
        enable = 1'b1;
        tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        rst_n = 1'b1;
        tick();
        enable = 1'b1;
        tick();
        test_reset();
        test_addr_read();
        test_ack_load();
        test_held_event();
        test_nack();
        test_write_collide();
        test_rx();
        test_rx_same_edge();
        test_disabled();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule